// File: doc/BRIEF.md
# Filtered Descriptor-Chain Receive DMA

This block takes Ethernet frames one byte per beat from an AXI4-Stream input, decides whether each frame is wanted, and copies every wanted frame into memory through a linked chain of descriptors. Each descriptor occupies three consecutive words: the frame buffer address at offset 0, a size word at offset 4 whose bit 31 marks the descriptor as empty (free for the engine) and whose bits [10:0] carry a length, and the address of the following descriptor at offset 8.

A frame is first held in a local buffer until its last byte arrives. Only then are the receive enables, the length limit and the destination address examined, so a rejected frame never touches a descriptor. A kept frame is written word by word to the current descriptor's buffer, the size word is rewritten with the bare length (which clears the empty mark), and the engine follows the next pointer. If the current descriptor is still owned by software, the engine raises an overflow flag and switches its own enable off instead of waiting.

Software drives the block through a few strobed fields: the receive enable with its descriptor base pointer, the maximum frame length, the station address, and acknowledge pulses for the received-frame counter and the overflow flag.

Top module: `rx_desc_dma`

## Requirements
- R1: A frame is kept only if, at its last byte, both `mac_rx_en` and the engine enable `dma_en` are 1; otherwise it causes no memory write and no counter change.
- R2: A frame whose byte count exceeds the 16-bit maximum-length field, or exceeds 2047 bytes, is dropped; the field resets to 0x600 and a length equal to the field is kept.
- R3: The destination (first six bytes) is accepted when it is all 0xFF or equals the station address, whose bytes in arrival order are `station_a[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, `station_b[15:8]`, `station_b[7:0]`; any other destination, or a frame shorter than six bytes, is dropped.
- R4: For a kept frame the engine reads the size word (pointer+4), buffer address (pointer+0) and next pointer (pointer+8), then writes the frame to consecutive words from the buffer address, byte k in bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4, unused bytes of the last word zero; each request is held until `mem_ack`.
- R5: After the data, the size word at pointer+4 is written as the length alone (bit 31 zero) and the current pointer becomes the next pointer.
- R6: Each stored frame increments the 8-bit `rx_count` and sets `pkt_rcvd`; `irq` is 1 whenever `pkt_rcvd` or `overflow` is 1; all status resets to 0.
- R7: If the size word read has bit 31 clear, nothing is written, `overflow` is set and `dma_en` is cleared.
- R8: A `ctl_we` with `ctl_en_wd`=1 sets `dma_en` and reloads the current pointer from `desc_base` with bits [1:0] forced to zero; with `ctl_en_wd`=0 it clears `dma_en`.
- R9: A `clr_ovf` pulse clears `overflow`; an `ack_pkt` pulse decrements `rx_count`, and `pkt_rcvd` clears only when the count reaches zero.
- R10: `s_tready` is 1 while frames are being collected and 0 from the cycle after a kept frame's last byte until its descriptor work ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 8 | Frame byte |
| s_tvalid | input | 1 | Byte valid |
| s_tlast | input | 1 | Last byte of frame |
| s_tready | output | 1 | Byte accepted when high with s_tvalid |
| mac_rx_en | input | 1 | MAC-level receive enable |
| ctl_we | input | 1 | Strobe writing the engine enable |
| ctl_en_wd | input | 1 | Enable value written by ctl_we |
| desc_base | input | 32 | Descriptor pointer loaded on enable |
| maxlen_we | input | 1 | Strobe writing the maximum length |
| maxlen_wd | input | 16 | Maximum frame length value |
| station_a | input | 32 | Station address bytes 1 to 4 |
| station_b | input | 16 | Station address bytes 5 and 6 |
| ack_pkt | input | 1 | Acknowledge one received frame |
| clr_ovf | input | 1 | Clear the overflow flag |
| dma_en | output | 1 | Engine enable |
| rx_count | output | 8 | Stored frames not yet acknowledged |
| pkt_rcvd | output | 1 | Frames pending acknowledge |
| overflow | output | 1 | Descriptor was not free |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the request |

## Verification
The assertions assume that the memory side raises `mem_ack` for exactly one cycle and only while `mem_req` is pending, that `ack_pkt` is never pulsed while `rx_count` is zero, and that the enable is not rewritten while a frame is being stored. The bench's memory model answers each request one cycle after it appears and drops `mem_ack` at once, and every software pulse is issued only after the engine has returned to collecting with a nonzero count where an acknowledge is given. The scoreboard predicts every memory write from the frame bytes and the descriptor layout it set up, so any unexpected or missing write is caught.

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int          BUF_WORDS  = 512,
  parameter int          LEN_W      = 11,
  parameter logic [15:0] MAXLEN_RST = 16'h0600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  output logic        s_tready,
  input  logic        mac_rx_en,
  input  logic        ctl_we,
  input  logic        ctl_en_wd,
  input  logic [31:0] desc_base,
  input  logic        maxlen_we,
  input  logic [15:0] maxlen_wd,
  input  logic [31:0] station_a,
  input  logic [15:0] station_b,
  input  logic        ack_pkt,
  input  logic        clr_ovf,
  output logic        dma_en,
  output logic [7:0]  rx_count,
  output logic        pkt_rcvd,
  output logic        overflow,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int WIDX_W  = $clog2(BUF_WORDS);
  localparam int BYTES   = BUF_WORDS * 4;
  localparam int LEN_MAX = (1 << LEN_W) - 1;
  localparam int CAP     = (BYTES < LEN_MAX) ? BYTES : LEN_MAX;

  typedef enum logic [2:0] {S_COLL, S_RSIZE, S_RBUF, S_RNEXT, S_WDATA, S_WSIZE} st_t;

  st_t               st;
  logic [31:0]       fbuf [BUF_WORDS];
  logic [15:0]       bcnt;
  logic [47:0]       da;
  logic [15:0]       maxlen;
  logic [LEN_W-1:0]  flen;
  logic [31:0]       ptr, bufa, nxt;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       wmask;

  wire        beat   = s_tvalid & s_tready;
  wire [47:0] da_n   = (bcnt < 16'd6) ? {da[39:0], s_tdata} : da;
  wire [16:0] len_n  = {1'b0, bcnt} + 17'd1;
  wire        hit    = (&da_n) | (da_n == {station_a, station_b});
  wire        keep   = dma_en & mac_rx_en & hit & (len_n >= 17'd6) &
                       (len_n <= {1'b0, maxlen}) & (len_n <= 17'(CAP));
  wire [WIDX_W-1:0] last_w = WIDX_W'((flen - 1'b1) >> 2);
  wire        ovf_ev = (st == S_RSIZE) & mem_ack & ~mem_rdata[31];
  wire        done   = (st == S_WSIZE) & mem_ack;
  wire [7:0]  cnt_n  = rx_count + {7'd0, done} - {7'd0, ack_pkt};

  assign s_tready = (st == S_COLL);
  assign mem_req  = (st != S_COLL);
  assign mem_we   = (st == S_WDATA) | (st == S_WSIZE);
  assign irq      = pkt_rcvd | overflow;

  always_comb begin
    for (int l = 0; l < 4; l++)
      wmask[8*l +: 8] = (widx != last_w || flen[1:0] == 2'd0 || l < int'(flen[1:0])) ? 8'hFF : 8'h00;
  end

  always_comb begin
    mem_addr  = ptr + 32'd4;
    mem_wdata = {{(32-LEN_W){1'b0}}, flen};
    case (st)
      S_RBUF:  mem_addr = ptr;
      S_RNEXT: mem_addr = ptr + 32'd8;
      S_WDATA: begin
        mem_addr  = bufa + {{(30-WIDX_W){1'b0}}, widx, 2'b00};
        mem_wdata = fbuf[widx] & wmask;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (beat && bcnt < 16'(BYTES))
      fbuf[bcnt[WIDX_W+1:2]][{bcnt[1:0], 3'b000} +: 8] <= s_tdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_COLL;
      bcnt <= '0;
      da <= '0;
      flen <= '0;
      bufa <= '0;
      nxt <= '0;
      widx <= '0;
    end else begin
      case (st)
        S_COLL: if (beat) begin
          da <= da_n;
          if (s_tlast) begin
            bcnt <= '0;
            flen <= len_n[LEN_W-1:0];
            if (keep) st <= S_RSIZE;
          end else if (!(&bcnt)) begin
            bcnt <= bcnt + 16'd1;
          end
        end
        S_RSIZE: if (mem_ack) st <= mem_rdata[31] ? S_RBUF : S_COLL;
        S_RBUF:  if (mem_ack) begin bufa <= mem_rdata; st <= S_RNEXT; end
        S_RNEXT: if (mem_ack) begin nxt <= mem_rdata; widx <= '0; st <= S_WDATA; end
        S_WDATA: if (mem_ack) begin
          if (widx == last_w) st <= S_WSIZE;
          else widx <= widx + 1'b1;
        end
        S_WSIZE: if (mem_ack) st <= S_COLL;
        default: st <= S_COLL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en <= 1'b0;
      ptr <= '0;
      maxlen <= MAXLEN_RST;
      rx_count <= '0;
      pkt_rcvd <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (ctl_we) dma_en <= ctl_en_wd;
      else if (ovf_ev) dma_en <= 1'b0;
      if (ctl_we && ctl_en_wd) ptr <= {desc_base[31:2], 2'b00};
      else if (done) ptr <= nxt;
      if (maxlen_we) maxlen <= maxlen_wd;
      rx_count <= cnt_n;
      if (done) pkt_rcvd <= 1'b1;
      else if (ack_pkt && cnt_n == 8'd0) pkt_rcvd <= 1'b0;
      if (ovf_ev) overflow <= 1'b1;
      else if (clr_ovf) overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_tready,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        dma_en,
  input logic        overflow,
  input logic        pkt_rcvd,
  input logic [7:0]  rx_count,
  input logic        ack_pkt,
  input logic        clr_ovf,
  input logic        ctl_we,
  input logic        ctl_en_wd
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !s_tready);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_pkt |=> (rx_count == $past(rx_count) || rx_count == $past(rx_count) + 8'd1));

  assert_pkt_on_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ack_pkt) && rx_count != $past(rx_count)) |-> pkt_rcvd);

  assert_ovf_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(overflow) && !$past(ctl_we)) |-> !dma_en);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr_ovf |=> overflow);

  assert_pkt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pkt_rcvd) |-> rx_count == 8'd0);

  assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_en_wd |=> dma_en);
endmodule

bind rx_desc_dma rx_desc_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_tready(s_tready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .dma_en(dma_en),
  .overflow(overflow), .pkt_rcvd(pkt_rcvd), .rx_count(rx_count),
  .ack_pkt(ack_pkt), .clr_ovf(clr_ovf), .ctl_we(ctl_we), .ctl_en_wd(ctl_en_wd)
);

// File: tb/test_rx_desc_dma.sv
module test_rx_desc_dma;
  logic clk = 0, rst_n = 0;
  logic [7:0] s_tdata = 0;
  logic s_tvalid = 0, s_tlast = 0, s_tready;
  logic mac_rx_en = 0, ctl_we = 0, ctl_en_wd = 0;
  logic [31:0] desc_base = 0;
  logic maxlen_we = 0;
  logic [15:0] maxlen_wd = 0;
  logic [31:0] station_a = 32'h02112233;
  logic [15:0] station_b = 16'h4455;
  logic ack_pkt = 0, clr_ovf = 0;
  logic dma_en, pkt_rcvd, overflow, irq;
  logic [7:0] rx_count;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  always #5 clk = ~clk;

  rx_desc_dma i_rx_desc_dma (.*);

  // memory model: one-cycle ack, bench-side setup port
  logic [31:0] mem [1024];
  logic tb_we = 0;
  logic [31:0] tb_addr = 0, tb_data = 0;
  always @(posedge clk) begin
    if (tb_we) mem[tb_addr[11:2]] <= tb_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end else mem_ack <= 1'b0;
  end

  typedef struct { logic [31:0] a; logic [31:0] d; string tag; } exp_t;
  exp_t q[$];
  int nchk = 0, nerr = 0, mchk = 0, merr = 0;
  bit finished = 0;
  logic [7:0] fb [2048];

  // monitor: every memory write must match the front of the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ack) begin
      mchk++;
      if (q.size() == 0) begin
        merr++;
        $display("FAIL R1/R3 unexpected write: got %h@%h expected none", mem_wdata, mem_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.a !== mem_addr || e.d !== mem_wdata) begin
          merr++;
          $display("FAIL %s write: got %h@%h expected %h@%h", e.tag, mem_wdata, mem_addr, e.d, e.a);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic mk_desc(input logic [31:0] a, input logic [31:0] b, input logic [31:0] sz, input logic [31:0] n);
    wr_word(a, b); wr_word(a + 4, sz); wr_word(a + 8, n);
  endtask

  task automatic fill(input logic [47:0] dst, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      fb[i] = (i < 6) ? dst[47 - 8*i -: 8] : 8'(seed + 8'(i));
  endtask

  task automatic send(input int n, input bit store, input logic [31:0] dsc, input logic [31:0] bufa, input string tag);
    if (store) begin
      for (int w = 0; w < (n + 3) / 4; w++) begin
        logic [31:0] d;
        d = '0;
        for (int b = 0; b < 4; b++)
          if (4*w + b < n) d[8*b +: 8] = fb[4*w + b];
        q.push_back('{bufa + 32'(4*w), d, tag});
      end
      q.push_back('{dsc + 32'd4, 32'(n), tag});
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!s_tready) @(negedge clk);
      s_tvalid = 1; s_tdata = fb[i]; s_tlast = (i == n - 1);
    end
    @(negedge clk); s_tvalid = 0; s_tlast = 0;
    if (store) chk("R10 ready low while storing", {31'd0, s_tready}, 32'd0);
    while (mem_req || !s_tready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_en(input logic v, input logic [31:0] base);
    @(negedge clk); ctl_we = 1; ctl_en_wd = v; desc_base = base;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack_pkt = 1; @(negedge clk); ack_pkt = 0;
  endtask

  task automatic status(input string tag, input int cnt, input bit pk, input bit ov, input bit en);
    chk({tag, " rx_count"}, {24'd0, rx_count}, 32'(cnt));
    chk({tag, " pkt_rcvd"}, {31'd0, pkt_rcvd}, {31'd0, pk});
    chk({tag, " overflow"}, {31'd0, overflow}, {31'd0, ov});
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, pk | ov});
    chk({tag, " dma_en"}, {31'd0, dma_en}, {31'd0, en});
  endtask

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] OWN   = 48'h0211_2233_4455;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    status("R6 reset", 0, 0, 0, 0);
    chk("R10 reset ready", {31'd0, s_tready}, 32'd1);
    mk_desc(32'h100, 32'h400, 32'h8000_0000, 32'h110);
    mk_desc(32'h110, 32'h500, 32'h8000_0000, 32'h120);
    mk_desc(32'h120, 32'h580, 32'h0000_0000, 32'h100);
    mk_desc(32'h130, 32'h600, 32'h8000_0000, 32'h140);
    mac_rx_en = 1;
    // R1: engine disabled
    fill(OWN, 10, 8'h10); send(10, 0, 0, 0, "R1");
    status("R1 engine off", 0, 0, 0, 0);
    // R8: base with low bits set is aligned
    set_en(1, 32'h103);
    // R1: MAC receive off
    mac_rx_en = 0;
    fill(OWN, 10, 8'h20); send(10, 0, 0, 0, "R1");
    mac_rx_en = 1;
    status("R1 mac off", 0, 0, 0, 1);
    // R2: default limit 0x600, 1537 bytes dropped
    fill(BCAST, 1537, 8'h30); send(1537, 0, 0, 0, "R2");
    status("R2 default limit", 0, 0, 0, 1);
    // R3 R4 R5: station match, 10 bytes into D0
    fill(OWN, 10, 8'h40); send(10, 1, 32'h100, 32'h400, "R4");
    status("R6 first frame", 1, 1, 0, 1);
    // R3: wrong last address byte
    fill(48'h0211_2233_4456, 12, 8'h50); send(12, 0, 0, 0, "R3");
    // R3: short broadcast
    fill(BCAST, 5, 8'h60); send(5, 0, 0, 0, "R3");
    status("R3 filtered", 1, 1, 0, 1);
    // R2: programmed limit 20
    @(negedge clk); maxlen_we = 1; maxlen_wd = 16'd20; @(negedge clk); maxlen_we = 0;
    fill(BCAST, 21, 8'h70); send(21, 0, 0, 0, "R2");
    status("R2 over limit", 1, 1, 0, 1);
    // R2 R5: length equal to limit kept in next descriptor D1
    fill(BCAST, 20, 8'h80); send(20, 1, 32'h110, 32'h500, "R5");
    status("R5 second frame", 2, 1, 0, 1);
    // R7: D2 is not free
    fill(BCAST, 8, 8'h90); send(8, 0, 0, 0, "R7");
    status("R7 overflow", 2, 1, 1, 0);
    // R1: after self-disable frames are dropped
    fill(BCAST, 8, 8'hA0); send(8, 0, 0, 0, "R1");
    // R9: clear overflow, acknowledge twice
    @(negedge clk); clr_ovf = 1; @(negedge clk); clr_ovf = 0;
    status("R9 overflow cleared", 2, 1, 0, 0);
    pulse_ack;
    status("R9 one ack", 1, 1, 0, 0);
    pulse_ack;
    status("R9 count zero", 0, 0, 0, 0);
    // R8: re-enable at D3
    set_en(1, 32'h130);
    fill(BCAST, 7, 8'hB0); send(7, 1, 32'h130, 32'h600, "R8");
    status("R8 reloaded", 1, 1, 0, 1);
    // R2: 2048 bytes exceed length field even with limit 0xFFFF
    @(negedge clk); maxlen_we = 1; maxlen_wd = 16'hFFFF; @(negedge clk); maxlen_we = 0;
    fill(BCAST, 2048, 8'hC0); send(2048, 0, 0, 0, "R2");
    status("R2 field limit", 1, 1, 0, 1);
    chk("R5 all writes seen", 32'(q.size()), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk + mchk, nerr + merr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk + mchk + 1, nerr + merr + 1);
      $finish;
    end
  end
endmodule